// File: doc/BRIEF.md
# Serial Control Port Slave

This block is the slave end of a synchronous serial control bus. A host lowers an active-low select, clocks an instruction byte and then a data field, and the block either stores that field into a bank of buffer registers or shifts a buffer register back out to the host. The buffer bank is presented whole on `buf_regs`. Moving those values into active registers is left to a separate update path outside this block.

The serial clock, select and data input are asynchronous to the core clock `clk`. Each passes through a synchronizer. Serial clock edges are then detected in the core domain: input data is taken on serial rising edges and read data is launched on serial falling edges. A register bit picks one of two line arrangements. In two-wire mode one shared line carries both directions, and the block drives it only while read data is being returned. In three-wire mode the shared line only receives, and read data leaves on a dedicated output. An active-high abort input clears the transfer logic asynchronously. The buffer bank is not affected by abort.

The transfer controller has five states. IDLE waits for select. INSTR collects the eight instruction bits. WR collects write data. RD returns read data. DONE holds until select is released. Its transitions are:
- IDLE to INSTR when select is low.
- INSTR to WR or RD on the eighth rising edge, according to the read flag.
- WR or RD to DONE on the last data edge.
- Any state to IDLE when select goes high, when abort is asserted, or on reset.

Top module: `scp_port`

## Requirements
- R1: After reset every buffer register reads zero, `sdio_oe` and `sdo` are low, and the port is in two-wire mode (register 0 bit 0 = 0).
- R2: While `cs_n` is high, serial clock edges and data have no effect: the bank is unchanged and no output is driven.
- R3: A transfer starts with an instruction byte sent MSB first. Bit 7 = 1 means read and 0 means write. Bits 4:0 are the register address. Bits 6:5 are ignored.
- R4: The data field length depends on the address: register 0 is 8 bits, 1 is 16, 2 is 32 and 3 is 24. Any other address uses 8 bits, its writes change nothing and it reads as zero.
- R5: Write data is shifted in MSB first on rising serial edges. It lands in the buffer register only when the last bit of the field has arrived. A transfer cut short by raising `cs_n` leaves the bank unchanged.
- R6: Read data is launched MSB first on each falling serial edge, starting with the fall right after the eighth instruction bit, and it is stable at the following rising edge.
- R7: In two-wire mode `sdio_oe` is high only during the data phase of a read, read data appears on `sdio_out`, and `sdo` stays low.
- R8: With register 0 bit 0 = 1 (three-wire mode), `sdio_oe` never rises and read data appears on `sdo`.
- R9: Raising `abort` ends the current transfer without waiting for a clock. `sdio_oe` drops at once and a pending write is discarded. Once `abort` is low again, a new instruction is accepted even if `cs_n` stayed low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock from host |
| cs_n | input | 1 | Active-low select |
| abort | input | 1 | Active-high asynchronous transfer abort |
| sdio_in | input | 1 | Receive side of the shared data line |
| sdio_out | output | 1 | Transmit side of the shared data line |
| sdio_oe | output | 1 | Drive enable for the shared data line |
| sdo | output | 1 | Dedicated read data output (three-wire mode) |
| buf_regs | output | 128 | Buffer bank, register i at bits [32*i+31:32*i] |

## Verification
Serial edges reach the controller after two synchronizer stages and one edge flop, so read data and the drive enable move about three core cycles after a serial falling edge. The bench therefore holds each serial half period for eight cycles and samples the data lines at the last cycle before the rising edge. A completed write shows on `buf_regs` about three cycles after the final rising edge, and the bench compares the bank against its own model only after select has been high for sixteen cycles. Abort acts without a clock, so it is checked one nanosecond after it rises, before any core edge. A per-cycle monitor also compares the drive enable and the dedicated output against the bench's own record of mode and read phase.

// File: rtl/scp_pkg.sv
`timescale 1ns/1ps
package scp_pkg;
    localparam int DW   = 32;
    localparam int AW   = 5;
    localparam int IW   = 8;
    localparam int NREG = 4;
    localparam int CW   = $clog2(DW + 1);
    localparam int MODE_REG = 0;
    localparam int MODE_BIT = 0;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_INSTR,
        ST_WR,
        ST_RD,
        ST_DONE
    } scp_state_e;

    function automatic logic [CW-1:0] field_len(input logic [AW-1:0] a);
        case (a)
            5'd0:    return CW'(8);
            5'd1:    return CW'(16);
            5'd2:    return CW'(32);
            5'd3:    return CW'(24);
            default: return CW'(8);
        endcase
    endfunction

    function automatic logic [DW-1:0] field_mask(input logic [AW-1:0] a);
        logic [CW-1:0] n;
        n = field_len(a);
        if (n >= CW'(DW)) return '1;
        return (DW'(1) << n) - DW'(1);
    endfunction
endpackage

// File: rtl/scp_sync.sv
`timescale 1ns/1ps
module scp_sync #(
    parameter int         W       = 3,
    parameter int         STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/scp_regbank.sv
`timescale 1ns/1ps
module scp_regbank
    import scp_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [AW-1:0]      wr_addr,
    input  logic [DW-1:0]      wr_data,
    input  logic [AW-1:0]      rd_addr,
    output logic [DW-1:0]      rd_data,
    output logic               mode3,
    output logic [NREG*DW-1:0] bank
);
    genvar g;
    generate
        for (g = 0; g < NREG; g++) begin : g_reg
            logic [DW-1:0] r_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    r_q <= '0;
                end else if (wr_en && (wr_addr == AW'(g))) begin
                    r_q <= wr_data & field_mask(AW'(g));
                end
            end
            assign bank[g*DW +: DW] = r_q;
        end
    endgenerate

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NREG; i++) begin
            if (rd_addr == AW'(i)) rd_data = bank[i*DW +: DW];
        end
    end

    assign mode3 = bank[MODE_REG*DW + MODE_BIT];

    // R5: the bank only moves on a commit pulse
    a_r5_bank_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(bank));

    // R4: a commit to an unmapped address changes nothing
    a_r4_unmapped_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_addr >= AW'(NREG))) |=> $stable(bank));
endmodule

// File: rtl/scp_fsm.sv
`timescale 1ns/1ps
module scp_fsm
    import scp_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          abort,
    input  logic          rise,
    input  logic          fall,
    input  logic          cs_n_s,
    input  logic          sdi_s,
    input  logic          mode3,
    input  logic [DW-1:0] rd_data,
    output logic [AW-1:0] rd_addr,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output logic          sdio_out,
    output logic          sdio_oe,
    output logic          sdo
);
    logic          xfer_rst;
    scp_state_e    state_q, state_d;
    logic [CW-1:0] bit_cnt_q;
    logic [CW-1:0] len_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] shreg_q;
    logic [DW-1:0] wr_data_q;
    logic          drv_q, out_q, wr_q;
    logic          instr_last, data_last;
    logic [CW-1:0] next_len;

    assign xfer_rst   = !rst_n || abort;
    assign rd_addr    = {shreg_q[AW-2:0], sdi_s};
    assign next_len   = field_len(rd_addr);
    assign instr_last = rise && (bit_cnt_q == CW'(IW - 1));
    assign data_last  = rise && (bit_cnt_q == len_q - CW'(1));

    // state register
    always_ff @(posedge clk or posedge xfer_rst) begin
        if (xfer_rst) state_q <= ST_IDLE;
        else          state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        if (cs_n_s) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_INSTR;
                ST_INSTR: if (instr_last) state_d = shreg_q[IW-2] ? ST_RD : ST_WR;
                ST_WR:    if (data_last) state_d = ST_DONE;
                ST_RD:    if (data_last) state_d = ST_DONE;
                ST_DONE:  state_d = ST_DONE;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    // datapath
    always_ff @(posedge clk or posedge xfer_rst) begin
        if (xfer_rst) begin
            bit_cnt_q <= '0;
            len_q     <= '0;
            addr_q    <= '0;
            shreg_q   <= '0;
            wr_data_q <= '0;
            drv_q     <= 1'b0;
            out_q     <= 1'b0;
            wr_q      <= 1'b0;
        end else begin
            wr_q <= 1'b0;
            if (cs_n_s) begin
                bit_cnt_q <= '0;
                drv_q     <= 1'b0;
                out_q     <= 1'b0;
            end else begin
                unique case (state_q)
                    ST_IDLE: bit_cnt_q <= '0;
                    ST_INSTR: begin
                        if (rise) begin
                            if (instr_last) begin
                                bit_cnt_q <= '0;
                                addr_q    <= rd_addr;
                                len_q     <= next_len;
                                shreg_q   <= shreg_q[IW-2] ?
                                             (rd_data << (DW - int'(next_len))) : '0;
                            end else begin
                                bit_cnt_q <= bit_cnt_q + CW'(1);
                                shreg_q   <= {shreg_q[DW-2:0], sdi_s};
                            end
                        end
                    end
                    ST_WR: begin
                        if (rise) begin
                            shreg_q <= {shreg_q[DW-2:0], sdi_s};
                            if (data_last) begin
                                wr_q      <= 1'b1;
                                wr_data_q <= {shreg_q[DW-2:0], sdi_s};
                            end else begin
                                bit_cnt_q <= bit_cnt_q + CW'(1);
                            end
                        end
                    end
                    ST_RD: begin
                        if (fall) begin
                            out_q   <= shreg_q[DW-1];
                            shreg_q <= {shreg_q[DW-2:0], 1'b0};
                            drv_q   <= 1'b1;
                        end
                        if (rise) begin
                            if (data_last) drv_q <= 1'b0;
                            else           bit_cnt_q <= bit_cnt_q + CW'(1);
                        end
                    end
                    ST_DONE: drv_q <= 1'b0;
                    default: drv_q <= 1'b0;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        wr_en    = wr_q;
        wr_addr  = addr_q;
        wr_data  = wr_data_q;
        sdio_oe  = drv_q && !mode3;
        sdio_out = drv_q && !mode3 && out_q;
        sdo      = drv_q && mode3 && out_q;
    end

    a_r7_oe_only_in_read: assert property (@(posedge clk) disable iff (xfer_rst)
        sdio_oe |-> (state_q == ST_RD));

    a_r8_no_oe_three_wire: assert property (@(posedge clk) disable iff (xfer_rst)
        mode3 |-> !sdio_oe);

    a_r7_sdo_quiet_two_wire: assert property (@(posedge clk) disable iff (xfer_rst)
        !mode3 |-> !sdo);

    a_r2_deselect_idle: assert property (@(posedge clk) disable iff (xfer_rst)
        cs_n_s |=> (state_q == ST_IDLE));

    a_r4_count_in_field: assert property (@(posedge clk) disable iff (xfer_rst)
        (state_q == ST_WR || state_q == ST_RD) |-> (bit_cnt_q < len_q));

    a_r5_commit_at_end: assert property (@(posedge clk) disable iff (xfer_rst)
        wr_q |-> (state_q == ST_DONE));

    a_r9_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
        abort |-> (state_q == ST_IDLE && !sdio_oe && !sdo));
endmodule

// File: rtl/scp_port.sv
`timescale 1ns/1ps
module scp_port
    import scp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sclk,
    input  logic               cs_n,
    input  logic               abort,
    input  logic               sdio_in,
    output logic               sdio_out,
    output logic               sdio_oe,
    output logic               sdo,
    output logic [NREG*DW-1:0] buf_regs
);
    logic          sclk_s, cs_n_s, sdi_s, sclk_d;
    logic          rise, fall;
    logic          mode3, wr_en;
    logic [AW-1:0] rd_addr, wr_addr;
    logic [DW-1:0] rd_data, wr_data;

    scp_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({sclk, cs_n, sdio_in}),
        .q     ({sclk_s, cs_n_s, sdi_s})
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sclk_d <= 1'b0;
        else        sclk_d <= sclk_s;
    end

    assign rise = sclk_s && !sclk_d;
    assign fall = !sclk_s && sclk_d;

    scp_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .abort    (abort),
        .rise     (rise),
        .fall     (fall),
        .cs_n_s   (cs_n_s),
        .sdi_s    (sdi_s),
        .mode3    (mode3),
        .rd_data  (rd_data),
        .rd_addr  (rd_addr),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .sdio_out (sdio_out),
        .sdio_oe  (sdio_oe),
        .sdo      (sdo)
    );

    scp_regbank u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .mode3   (mode3),
        .bank    (buf_regs)
    );
endmodule

// File: tb/scp_port_tb_top.sv
`timescale 1ns/1ps
module scp_port_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int H          = 8;
    localparam int LIMIT      = 150000;

    logic clk = 1'b0;
    logic rst_n, sclk, cs_n, abort, tb_sdi;
    logic sdio_out, sdio_oe, sdo;
    logic [127:0] buf_regs;
    bit   tb_drive, rd_phase, model_3w, done;
    int   total, bad, cyc;
    logic [31:0] model [4];

    always #(CLK_PERIOD/2) clk = ~clk;

    scp_port dut_i (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .abort(abort),
        .sdio_in(tb_sdi), .sdio_out(sdio_out), .sdio_oe(sdio_oe), .sdo(sdo),
        .buf_regs(buf_regs)
    );

    function automatic int blen(input int a);
        case (a)
            0: return 8;
            1: return 16;
            2: return 32;
            3: return 24;
            default: return 8;
        endcase
    endfunction

    function automatic logic [31:0] bmask(input int a);
        int n = blen(a);
        return (n == 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 32'd1);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_bank(input string req);
        for (int i = 0; i < 4; i++)
            chk(buf_regs[i*32 +: 32] === model[i], req, buf_regs[i*32 +: 32], model[i]);
    endtask

    task automatic put_bit(input logic b);
        tb_sdi = b; tb_drive = 1'b1;
        repeat (H) @(negedge clk);
        sclk = 1'b1;
        repeat (H) @(negedge clk);
        sclk = 1'b0;
    endtask

    task automatic get_bit(output logic b);
        tb_drive = 1'b0;
        repeat (H) @(negedge clk);
        b = model_3w ? sdo : sdio_out;
        chk(sdio_oe === !model_3w, model_3w ? "R8 oe" : "R7 oe", {31'd0, sdio_oe}, {31'd0, !model_3w});
        sclk = 1'b1;
        repeat (H) @(negedge clk);
        sclk = 1'b0;
    endtask

    task automatic end_xfer();
        repeat (H) @(negedge clk);
        cs_n = 1'b1; tb_drive = 1'b0;
        repeat (2*H) @(negedge clk);
    endtask

    task automatic send_instr(input logic [7:0] ins);
        cs_n = 1'b0;
        for (int i = 7; i >= 0; i--) put_bit(ins[i]);
    endtask

    task automatic do_write(input logic [7:0] ins, input logic [31:0] d, input int n);
        send_instr(ins);
        for (int i = n - 1; i >= 0; i--) put_bit(d[i]);
        end_xfer();
        if (n == blen(int'(ins[4:0])) && ins[4:0] < 5'd4) begin
            model[ins[4:0]] = d & bmask(int'(ins[4:0]));
            if (ins[4:0] == 5'd0) model_3w = d[0];
        end
    endtask

    task automatic do_read(input logic [7:0] ins, input string req);
        logic [31:0] got = '0;
        logic [31:0] exp;
        logic b;
        int n = blen(int'(ins[4:0]));
        exp = (ins[4:0] < 5'd4) ? model[ins[4:0]] : 32'd0;
        send_instr(ins);
        rd_phase = 1'b1;
        for (int i = 0; i < n; i++) begin
            get_bit(b);
            got = {got[30:0], b};
        end
        rd_phase = 1'b0;
        end_xfer();
        chk(got === exp, req, got, exp);
    endtask

    // per-cycle monitor of line ownership against the bench's own record
    always @(negedge clk) begin
        if (rst_n === 1'b1 && !done) begin
            cyc++;
            chk(!(tb_drive && sdio_oe), "R7 contention", {31'd0, sdio_oe}, 32'd0);
            chk(!(sdio_oe && !rd_phase), "R7 oe outside read", {31'd0, sdio_oe}, 32'd0);
            chk(!(sdio_oe && model_3w), "R8 oe in three-wire", {31'd0, sdio_oe}, 32'd0);
            chk(!(sdo && !model_3w), "R7 sdo in two-wire", {31'd0, sdo}, 32'd0);
            if (cyc > LIMIT) begin
                bad++;
                $display("FAIL watchdog actual=%0d expected<=%0d", cyc, LIMIT);
                $display("  test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        logic b;
        rst_n = 1'b0; sclk = 1'b0; cs_n = 1'b1; abort = 1'b0; tb_sdi = 1'b0;
        tb_drive = 1'b0; rd_phase = 1'b0; model_3w = 1'b0; done = 1'b0;
        total = 0; bad = 0; cyc = 0;
        for (int i = 0; i < 4; i++) model[i] = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1 reset state
        check_bank("R1 bank");
        chk(sdio_oe === 1'b0, "R1 oe", {31'd0, sdio_oe}, 32'd0);
        chk(sdo === 1'b0, "R1 sdo", {31'd0, sdo}, 32'd0);

        // R2 deselected traffic is ignored
        for (int i = 7; i >= 0; i--) put_bit(8'h01 >> i);
        for (int i = 0; i < 16; i++) put_bit(1'b1);
        tb_drive = 1'b0;
        repeat (2*H) @(negedge clk);
        check_bank("R2 deselected");

        // R3 R4 R5 writes of every mapped length, instruction bits 6:5 ignored
        do_write(8'h01, 32'h0000_BEEF, 16);
        check_bank("R5 write r1");
        do_write(8'h02, 32'hA5C3_0F81, 32);
        check_bank("R4 write r2");
        do_write(8'h63, 32'h0012_3456, 24);
        check_bank("R3 ignored bits 6:5");

        // R6 R7 reads in two-wire mode
        do_read(8'h81, "R6 read r1");
        do_read(8'hE2, "R3 read r2 with bits 6:5 set");
        do_read(8'h83, "R7 read r3");

        // R5 short write is dropped
        do_write(8'h01, 32'h0000_03FF, 10);
        check_bank("R5 partial write");

        // R4 unmapped address
        do_write(8'h09, 32'h0000_00FF, 8);
        check_bank("R4 unmapped write");
        do_read(8'h89, "R4 unmapped read");

        // R9 abort during a write
        send_instr(8'h02);
        for (int i = 0; i < 20; i++) put_bit(i[0]);
        abort = 1'b1;
        repeat (3) @(negedge clk);
        abort = 1'b0;
        end_xfer();
        check_bank("R9 write aborted");

        // R9 abort during a read, then a new transfer with select still low
        send_instr(8'h82);
        rd_phase = 1'b1;
        for (int i = 0; i < 3; i++) begin
            get_bit(b);
            chk(b === model[2][31-i], "R6 partial read bit", {31'd0, b}, {31'd0, model[2][31-i]});
        end
        abort = 1'b1;
        #1;
        chk(sdio_oe === 1'b0, "R9 oe drops at once", {31'd0, sdio_oe}, 32'd0);
        rd_phase = 1'b0;
        repeat (4) @(negedge clk);
        abort = 1'b0;
        repeat (2) @(negedge clk);
        do_write(8'h01, 32'h0000_1234, 16);
        check_bank("R9 transfer after abort");

        // R8 three-wire mode
        do_write(8'h00, 32'h0000_0001, 8);
        check_bank("R8 mode write");
        do_read(8'h83, "R8 read r3 on sdo");
        do_read(8'h80, "R8 read mode reg");
        do_write(8'h00, 32'h0000_0000, 8);
        do_read(8'h81, "R7 back to two-wire");
        check_bank("R7 final bank");

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule